// File: doc/BRIEF.md
# Three-Step Block-Matching Search Sequencer

This block steers a three-step motion search for one block of a video frame. It issues candidate displacements (u, v) one at a time to an external cost engine and reads back one matching cost (a sum of absolute differences) per candidate. From those costs it decides where to search next. It does not fetch pixels, compute costs or store frames.

A search starts from displacement (0, 0) with a spacing of 4. Each step evaluates the current centre and the eight points around it on a square grid at the current spacing. The centre then moves to the cheapest of those points and the spacing halves. After the spacing-1 step the block reports the winning displacement as the motion vector, together with its cost. The motion vector is the offset from the current block's position to the matched block's position in the reference frame. Any point outside the ±RANGE search window is skipped without a request. The cost of a step's centre is already known from the step before, so it is not requested again.

Top module: `tss_search`

## Requirements
- R1: After reset, candValid and done are both 0.
- R2: A start pulse seen while idle begins a search whose first request is (0, 0). Each request holds candValid, candU and candV steady until the cycle in which costValid is 1. That cycle completes the request, and the next request follows no earlier than the next cycle.
- R3: The spacing is 4, then 2, then 1. Within a step, the eight surrounding points are requested in this order of (du, dv) multiples of the spacing: (-1,-1), (0,-1), (1,-1), (-1,0), (1,0), (-1,1), (0,1), (1,1). u is horizontal and v is vertical.
- R4: After each step, the centre becomes the cheapest point evaluated in that step. After the third step, mvX/mvY is the final cheapest point and minSad is its cost.
- R5: A candidate replaces the current best only if its cost is strictly lower. On a tie the earlier-evaluated point wins, and the step's centre counts as evaluated first.
- R6: The centre is requested only in the first step. With every point inside the window, a search makes exactly 25 requests.
- R7: A point with |u| > RANGE or |v| > RANGE is never requested and cannot become the result.
- R8: done is a single-cycle pulse with no request outstanding. mvX, mvY and minSad are valid in that cycle.
- R9: A start pulse during a search is ignored. The search, its request sequence and its result are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (honoured only while idle) |
| candValid | output | 1 | Candidate request outstanding |
| candU | output | MV_W | Candidate horizontal displacement, signed |
| candV | output | MV_W | Candidate vertical displacement, signed |
| costValid | input | 1 | Cost for the outstanding candidate is on cost |
| cost | input | SAD_W | Matching cost of the outstanding candidate |
| done | output | 1 | Search finished, result valid this cycle |
| mvX | output | MV_W | Motion vector, horizontal, signed |
| mvY | output | MV_W | Motion vector, vertical, signed |
| minSad | output | SAD_W | Cost of the motion vector |

## Verification
The bench builds two copies side by side. One uses RANGE = 7, where the steps of 4, 2 and 1 can reach the window edge but never cross it, so every search makes the full 25 requests. The other uses RANGE = 5, where a centre that has moved to ±4 puts spacing-2 points at ±6. That makes window skipping and its effect on the request count and the result observable. Cost tables with only a few distinct values make ties common in both copies.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int NUM_STEPS = 3;
  localparam int STEP0     = 1 << (NUM_STEPS - 1);
  localparam int LAST_IDX  = 8;

  typedef enum logic [1:0] {S_IDLE, S_ASK, S_STEPEND, S_FIN} state_t;

  typedef struct packed {
    logic clear;     // begin a new search at (0,0)
    logic take;      // a cost arrived for the shown candidate
    logic first;     // shown candidate is the very first of the search
    logic recentre;  // move the centre onto the step winner
  } dpCtl_t;

  // Unit grid offset of candidate slot k (slot 0 is the centre).
  function automatic int offX(input logic [3:0] k);
    case (k)
      4'd1, 4'd4, 4'd6: offX = -1;
      4'd3, 4'd5, 4'd8: offX = 1;
      default:          offX = 0;
    endcase
  endfunction

  function automatic int offY(input logic [3:0] k);
    case (k)
      4'd1, 4'd2, 4'd3: offY = -1;
      4'd6, 4'd7, 4'd8: offY = 1;
      default:          offY = 0;
    endcase
  endfunction
endpackage

// File: rtl/tss_ctrl.sv
module tss_ctrl
  import tss_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       costValid,
  input  logic       inWin,
  output logic       candValid,
  output logic       done,
  output logic [3:0] idx,
  output logic [1:0] stepIdx,
  output dpCtl_t     ctl
);
  state_t state;
  logic   lastStep;

  assign lastStep = (stepIdx == 2'(NUM_STEPS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      idx     <= '0;
      stepIdx <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          idx     <= '0;
          stepIdx <= '0;
          state   <= S_ASK;
        end
        S_ASK: if (!inWin || costValid) begin
          if (idx == 4'(LAST_IDX)) state <= S_STEPEND;
          else                     idx   <= idx + 4'd1;
        end
        S_STEPEND: begin
          if (lastStep) state <= S_FIN;
          else begin
            stepIdx <= stepIdx + 2'd1;
            idx     <= 4'd1;
            state   <= S_ASK;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    candValid    = (state == S_ASK) && inWin;
    done         = (state == S_FIN);
    ctl.clear    = (state == S_IDLE) && start;
    ctl.take     = (state == S_ASK) && inWin && costValid;
    ctl.first    = (idx == 4'd0);
    ctl.recentre = (state == S_STEPEND) && !lastStep;
  end
endmodule

// File: rtl/tss_datapath.sv
module tss_datapath
  import tss_pkg::*;
#(
  parameter int RANGE = 7,
  parameter int SAD_W = 16,
  parameter int MV_W  = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  input  logic [3:0]              idx,
  input  logic [1:0]              stepIdx,
  input  logic [SAD_W-1:0]        cost,
  output logic signed [MV_W-1:0]  candU,
  output logic signed [MV_W-1:0]  candV,
  output logic                    inWin,
  output logic signed [MV_W-1:0]  bestX,
  output logic signed [MV_W-1:0]  bestY,
  output logic [SAD_W-1:0]        bestCost
);
  logic signed [MV_W-1:0] centreX, centreY;
  int candUi, candVi, stepLen;

  always_comb begin
    stepLen = STEP0 >> stepIdx;
    candUi  = int'(centreX) + offX(idx) * stepLen;
    candVi  = int'(centreY) + offY(idx) * stepLen;
    inWin   = (candUi >= -RANGE) && (candUi <= RANGE) &&
              (candVi >= -RANGE) && (candVi <= RANGE);
    candU   = candUi[MV_W-1:0];
    candV   = candVi[MV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      centreX  <= '0;
      centreY  <= '0;
      bestX    <= '0;
      bestY    <= '0;
      bestCost <= '0;
    end else begin
      if (ctl.take && (ctl.first || cost < bestCost)) begin
        bestX    <= candU;
        bestY    <= candV;
        bestCost <= cost;
      end
      if (ctl.recentre) begin
        centreX <= bestX;
        centreY <= bestY;
      end
    end
  end
endmodule

// File: rtl/tss_search.sv
module tss_search
  import tss_pkg::*;
#(
  parameter int RANGE = 7,
  parameter int SAD_W = 16,
  parameter int MV_W  = $clog2(RANGE + STEP0 + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  output logic                    candValid,
  output logic signed [MV_W-1:0]  candU,
  output logic signed [MV_W-1:0]  candV,
  input  logic                    costValid,
  input  logic [SAD_W-1:0]        cost,
  output logic                    done,
  output logic signed [MV_W-1:0]  mvX,
  output logic signed [MV_W-1:0]  mvY,
  output logic [SAD_W-1:0]        minSad
);
  dpCtl_t     ctl;
  logic [3:0] idx;
  logic [1:0] stepIdx;
  logic       inWin;

  tss_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .costValid(costValid),
    .inWin(inWin), .candValid(candValid), .done(done),
    .idx(idx), .stepIdx(stepIdx), .ctl(ctl)
  );

  tss_datapath #(.RANGE(RANGE), .SAD_W(SAD_W), .MV_W(MV_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .idx(idx), .stepIdx(stepIdx),
    .cost(cost), .candU(candU), .candV(candV), .inWin(inWin),
    .bestX(mvX), .bestY(mvY), .bestCost(minSad)
  );
endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
  parameter int RANGE = 7,
  parameter int MV_W  = 5
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   candValid,
  input logic                   costValid,
  input logic signed [MV_W-1:0] candU,
  input logic signed [MV_W-1:0] candV,
  input logic                   done,
  input logic signed [MV_W-1:0] mvX,
  input logic signed [MV_W-1:0] mvY
);
  a_r2_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    candValid && !costValid |=> candValid && $stable(candU) && $stable(candV));

  a_r7_in_window: assert property (@(posedge clk) disable iff (!rstN)
    candValid |-> (int'(candU) >= -RANGE) && (int'(candU) <= RANGE) &&
                  (int'(candV) >= -RANGE) && (int'(candV) <= RANGE));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_done_no_request: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !candValid);

  a_r4_result_in_window: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (int'(mvX) >= -RANGE) && (int'(mvX) <= RANGE) &&
             (int'(mvY) >= -RANGE) && (int'(mvY) <= RANGE));
endmodule

bind tss_search tss_checker #(.RANGE(RANGE), .MV_W(MV_W)) u_chk (
  .clk(clk), .rstN(rstN), .candValid(candValid), .costValid(costValid),
  .candU(candU), .candV(candV), .done(done), .mvX(mvX), .mvY(mvY)
);

// File: tb/sim_tss_search.sv
`timescale 1ns/1ps
module sim_tss_search;
  localparam int SAD_W = 16;
  localparam int MV_W  = 5;
  localparam int RNG0  = 7;
  localparam int RNG1  = 5;

  logic clk = 0;
  logic rstN = 0;
  logic start = 0;
  always #4 clk = ~clk;

  logic                   candValid [2];
  logic signed [MV_W-1:0] candU [2], candV [2];
  logic                   costValid [2];
  logic [SAD_W-1:0]       cost [2];
  logic                   done [2];
  logic signed [MV_W-1:0] mvX [2], mvY [2];
  logic [SAD_W-1:0]       minSad [2];

  tss_search #(.RANGE(RNG0), .SAD_W(SAD_W), .MV_W(MV_W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .candValid(candValid[0]),
    .candU(candU[0]), .candV(candV[0]), .costValid(costValid[0]), .cost(cost[0]),
    .done(done[0]), .mvX(mvX[0]), .mvY(mvY[0]), .minSad(minSad[0]));

  tss_search #(.RANGE(RNG1), .SAD_W(SAD_W), .MV_W(MV_W)) u1 (
    .clk(clk), .rstN(rstN), .start(start), .candValid(candValid[1]),
    .candU(candU[1]), .candV(candV[1]), .costValid(costValid[1]), .cost(cost[1]),
    .done(done[1]), .mvX(mvX[1]), .mvY(mvY[1]), .minSad(minSad[1]));

  int checks = 0, fails = 0, cycles = 0;
  int tab [0:14][0:14];
  int expU [2][32], expV [2][32], expN [2], expX [2], expY [2], expS [2];
  int reqN [2], gotX [2], gotY [2], gotS [2];
  bit doneSeen [2];

  function automatic int tabAt(int u, int v);
    return tab[u + 7][v + 7];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference search built from R3..R7.
  task automatic model(int d, int rng);
    int cx, cy, bx, by, bc, s, u, v, du, dv, n;
    cx = 0; cy = 0; bx = 0; by = 0; bc = 0; s = 4; n = 0;
    for (int st = 0; st < 3; st++) begin
      for (int k = 0; k < 9; k++) begin
        if (k == 0 && st > 0) continue;
        if (k == 0) begin du = 0; dv = 0; end
        else if (k <= 3) begin du = k - 2; dv = -1; end
        else if (k == 4) begin du = -1; dv = 0; end
        else if (k == 5) begin du = 1; dv = 0; end
        else begin du = k - 7; dv = 1; end
        u = cx + du * s; v = cy + dv * s;
        if (u < -rng || u > rng || v < -rng || v > rng) continue;
        expU[d][n] = u; expV[d][n] = v; n++;
        if (k == 0 || tabAt(u, v) < bc) begin bc = tabAt(u, v); bx = u; by = v; end
      end
      cx = bx; cy = by; s = s / 2;
    end
    expN[d] = n; expX[d] = bx; expY[d] = by; expS[d] = bc;
  endtask

  task automatic responder(int d);
    forever begin
      @(negedge clk);
      if (costValid[d]) costValid[d] = 0;
      else if (candValid[d]) begin
        repeat ($urandom % 3) @(negedge clk);
        if (reqN[d] < expN[d]) begin
          check(int'(candU[d]) == expU[d][reqN[d]], "R3/R7", $sformatf("u%0d req %0d u", d, reqN[d]),
                int'(candU[d]), expU[d][reqN[d]]);
          check(int'(candV[d]) == expV[d][reqN[d]], "R3/R7", $sformatf("u%0d req %0d v", d, reqN[d]),
                int'(candV[d]), expV[d][reqN[d]]);
        end else check(0, "R6", $sformatf("u%0d extra request", d), reqN[d] + 1, expN[d]);
        cost[d] = SAD_W'(tabAt(int'(candU[d]), int'(candV[d])));
        reqN[d]++;
        costValid[d] = 1;
      end
    end
  endtask

  task automatic watchDone(int d);
    forever begin
      @(negedge clk);
      if (done[d]) begin
        gotX[d] = int'(mvX[d]); gotY[d] = int'(mvY[d]); gotS[d] = int'(minSad[d]);
        doneSeen[d] = 1;
      end
    end
  endtask

  task automatic runTrial(string tag, bit extraStart);
    model(0, RNG0); model(1, RNG1);
    for (int d = 0; d < 2; d++) begin reqN[d] = 0; doneSeen[d] = 0; end
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (extraStart) begin
      repeat (12) @(negedge clk);
      start = 1; @(negedge clk); start = 0;   // R9: must be ignored
    end
    while (!(doneSeen[0] && doneSeen[1])) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      check(gotX[d] == expX[d], "R4", $sformatf("%s u%0d mvX", tag, d), gotX[d], expX[d]);
      check(gotY[d] == expY[d], "R4", $sformatf("%s u%0d mvY", tag, d), gotY[d], expY[d]);
      check(gotS[d] == expS[d], "R8", $sformatf("%s u%0d minSad", tag, d), gotS[d], expS[d]);
      check(reqN[d] == expN[d], "R6", $sformatf("%s u%0d requests", tag, d), reqN[d], expN[d]);
    end
    repeat (4) @(negedge clk);
    check(!candValid[0] && !candValid[1], "R9", $sformatf("%s idle after done", tag),
          int'(candValid[0]) + int'(candValid[1]), 0);
  endtask

  task automatic fillSmooth(int tx, int ty);
    for (int i = 0; i < 15; i++)
      for (int j = 0; j < 15; j++)
        tab[i][j] = 3 * ((i - 7 - tx) < 0 ? tx - i + 7 : i - 7 - tx)
                  + 3 * ((j - 7 - ty) < 0 ? ty - j + 7 : j - 7 - ty);
  endtask

  task automatic fillRandom(int span);
    for (int i = 0; i < 15; i++)
      for (int j = 0; j < 15; j++) tab[i][j] = int'($urandom % span);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int d = 0; d < 2; d++) begin costValid[d] = 0; cost[d] = '0; expN[d] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!candValid[0] && !done[0], "R1", "u0 outputs in reset", int'(candValid[0]) + int'(done[0]), 0);
    check(!candValid[1] && !done[1], "R1", "u1 outputs in reset", int'(candValid[1]) + int'(done[1]), 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(!candValid[0] && !done[0], "R1", "u0 idle after reset", int'(candValid[0]) + int'(done[0]), 0);
    fork
      responder(0); responder(1); watchDone(0); watchDone(1);
    join_none

    // R4/R7 directed: target in the far corner
    fillSmooth(7, 7);
    runTrial("corner", 0);
    check(gotX[0] == 7 && gotY[0] == 7, "R4", "u0 reaches corner", gotX[0] * 16 + gotY[0], 7 * 16 + 7);
    check(gotX[1] == 5 && gotY[1] == 5, "R7", "u1 clipped result", gotX[1] * 16 + gotY[1], 5 * 16 + 5);
    check(reqN[0] == 25, "R6", "u0 full request count", reqN[0], 25);
    check(reqN[1] == 20, "R7", "u1 request count with skips", reqN[1], 20);

    // R5: flat cost keeps the starting point
    for (int i = 0; i < 15; i++) for (int j = 0; j < 15; j++) tab[i][j] = 5;
    runTrial("flat", 0);
    check(gotX[0] == 0 && gotY[0] == 0, "R5", "u0 ties keep centre", gotX[0] * 16 + gotY[0], 0);

    // R9: a second start in mid-search is ignored
    fillSmooth(-3, 6);
    runTrial("busystart", 1);

    // R2/R3/R5: random costs, narrow span gives many ties
    for (int t = 0; t < 12; t++) begin
      fillRandom(4);
      runTrial($sformatf("tie%0d", t), t % 4 == 0);
    end
    for (int t = 0; t < 10; t++) begin
      fillRandom(1000);
      runTrial($sformatf("rnd%0d", t), 0);
    end
    for (int t = 0; t < 6; t++) begin
      fillSmooth(int'($urandom % 15) - 7, int'($urandom % 15) - 7);
      runTrial($sformatf("smooth%0d", t), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule